// File: doc/BRIEF.md
# Fault-Isolating Router Input Channel

This block is one input channel of a mesh router port. Words arrive from the neighbouring router over a credit-based wormhole link. Each word is 20 bits wide: a 16-bit flit followed by a 4-bit checksum. The channel checks the checksum twice:

- when a word comes off the link, which catches wiring faults;
- when the word reaches the head of a small input buffer, which catches storage upsets.

Good flits go out in order on a valid/ready interface towards the switch.

When either check fails, the channel isolates itself. It raises a fault flag towards the sending router and stops presenting flits downstream. It keeps returning credits, both for the words still arriving and for the words it discards from its buffer, so the sender drains the rest of the packet and never stalls. The channel stays isolated until an external restore pulse clears the flag and empties the buffer.

Top module: `fiso_rx_channel`

## Requirements
- R1: The checksum is a CRC with generator x^4 + x + 1 and a zero start value, shifted over the flit bits most significant bit first. Word bits 19:4 carry the flit and bits 3:0 carry the CRC. A word whose CRC matches is delivered on `dn_flit_o` with `dn_valid_o` high, one cycle after it is taken from the link.
- R2: A word that arrives with a mismatching CRC is not stored, and `link_fault_o` is high from the next cycle.
- R3: A stored word that fails the check at the buffer head is never shown downstream. `dn_valid_o` is low while it sits at the head, the word is discarded at the next edge, and `link_fault_o` rises.
- R4: While `link_fault_o` is high, `dn_valid_o` stays low whatever arrives.
- R5: `link_credit_o` gives the number of credits returned this cycle (0, 1 or 2). Each credit covers one word that left the buffer, whether delivered or discarded, or one incoming word that was dropped. The credit appears one cycle after the event.
- R6: While isolated, incoming words are dropped, and buffered words are discarded at one per cycle. Each of these returns a credit, so an incoming drop and a buffer discard in the same cycle give a count of 2.
- R7: The buffer holds 4 words. With `dn_ready_i` low, 4 words are held and no credit is returned for them. They then leave in arrival order, with one credit each.
- R8: The fault flag holds until `restore_i` is sampled high. That edge clears the flag and empties the buffer without returning credits for the flushed words.
- R9: After reset the fault flag, `dn_valid_o` and `link_credit_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| link_valid_i | input | 1 | A word is on the link this cycle |
| link_word_i | input | 20 | Flit in bits 19:4, CRC in bits 3:0 |
| link_credit_o | output | 2 | Credits returned to the sender this cycle |
| link_fault_o | output | 1 | Channel isolated, sent back to the sender |
| restore_i | input | 1 | Clears isolation and flushes the buffer |
| dn_valid_o | output | 1 | Flit offered downstream |
| dn_flit_o | output | 16 | Flit data offered downstream |
| dn_ready_i | input | 1 | Downstream accepts the flit |

## Verification
The hardest case to reach is a word that passes the link check and then fails at the buffer head. No port can corrupt stored data. The bench therefore pushes a good word, then overwrites the stored copy with one CRC bit flipped, in the cycle before it would be delivered. It then confirms that the valid output drops at once, that a credit comes back, and that the fault flag rises. The double-credit cycle is the other case that takes planning. It is reached by holding the downstream side stalled with words buffered, tripping a fault, and sending one more word while the buffer is still being scrapped.

// File: rtl/fiso_pkg.sv
package fiso_pkg;
  localparam int FLIT_W = 16;
  localparam int CRC_W  = 4;
  localparam int WORD_W = FLIT_W + CRC_W;
  localparam int CRED_W = 2;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;  // x^4 + x + 1, top term implied

  // Serial CRC, zero start, flit MSB first
  function automatic logic [CRC_W-1:0] crc4_calc(input logic [FLIT_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = FLIT_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/fiso_crc_chk.sv
module fiso_crc_chk
  import fiso_pkg::*;
(
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bad_o
);
  logic [CRC_W-1:0] expect_crc;
  assign expect_crc = crc4_calc(word_i[WORD_W-1:CRC_W]);
  assign bad_o      = valid_i && (expect_crc != word_i[CRC_W-1:0]);
endmodule

// File: rtl/fiso_fifo.sv
module fiso_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PTR_W-1:0]        wr_q, rd_q;
  logic [CNT_W-1:0]        cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= ptr_next(wr_q);
      end
      if (pop_i) rd_q <= ptr_next(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R8
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/fiso_isolator.sv
module fiso_isolator
  import fiso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restore_i,
  input  logic              in_valid_i,
  input  logic              in_bad_i,
  input  logic              head_bad_i,
  input  logic              empty_i,
  input  logic              dn_ready_i,
  output logic              push_o,
  output logic              pop_o,
  output logic              dn_valid_o,
  output logic              fault_o,
  output logic [CRED_W-1:0] credit_o
);
  logic              fault_q;
  logic [CRED_W-1:0] credit_q;
  logic              in_drop, head_live, deliver, scrap, trip;

  assign push_o     = in_valid_i && !in_bad_i && !fault_q && !restore_i;
  assign in_drop    = in_valid_i && !push_o;
  assign head_live  = !empty_i && !restore_i;
  assign dn_valid_o = head_live && !fault_q && !head_bad_i;
  assign deliver    = dn_valid_o && dn_ready_i;
  assign scrap      = head_live && (fault_q || head_bad_i);
  assign pop_o      = deliver || scrap;
  assign trip       = (in_valid_i && in_bad_i) || (!empty_i && head_bad_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fault_q  <= 1'b0;
      credit_q <= '0;
    end else begin
      fault_q  <= restore_i ? 1'b0 : (fault_q || trip);
      credit_q <= CRED_W'(in_drop) + CRED_W'(pop_o);
    end
  end

  assign fault_o  = fault_q;
  assign credit_o = credit_q;

  // R2
  entry_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_bad_i && !restore_i) |=> fault_o);
  // R3
  exit_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_i && head_bad_i && !restore_i) |=> fault_o);
  // R8
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !restore_i) |=> fault_o);
  // R8
  restore_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> !fault_o);
  // R5
  credit_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o || in_drop) |=> (credit_o != '0));
endmodule

// File: rtl/fiso_rx_channel.sv
module fiso_rx_channel
  import fiso_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_valid_i,
  input  logic [WORD_W-1:0] link_word_i,
  output logic [CRED_W-1:0] link_credit_o,
  output logic              link_fault_o,
  input  logic              restore_i,
  output logic              dn_valid_o,
  output logic [FLIT_W-1:0] dn_flit_o,
  input  logic              dn_ready_i
);
  logic              in_bad, head_bad, empty, full, push, pop;
  logic [WORD_W-1:0] head_word;

  fiso_crc_chk u_entry_chk (
    .valid_i(link_valid_i), .word_i(link_word_i), .bad_o(in_bad)
  );

  fiso_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(restore_i),
    .push_i(push), .din_i(link_word_i), .pop_i(pop),
    .dout_o(head_word), .empty_o(empty), .full_o(full)
  );

  fiso_crc_chk u_exit_chk (
    .valid_i(!empty), .word_i(head_word), .bad_o(head_bad)
  );

  fiso_isolator u_iso (
    .clk_i(clk_i), .rst_ni(rst_ni), .restore_i(restore_i),
    .in_valid_i(link_valid_i), .in_bad_i(in_bad),
    .head_bad_i(head_bad), .empty_i(empty), .dn_ready_i(dn_ready_i),
    .push_o(push), .pop_o(pop), .dn_valid_o(dn_valid_o),
    .fault_o(link_fault_o), .credit_o(link_credit_o)
  );

  assign dn_flit_o = head_word[WORD_W-1:CRC_W];

  // R4
  isolated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fault_o |-> !dn_valid_o);
  // R7
  full_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !(push && !pop));
endmodule

// File: tb/test_fiso_rx_channel.sv
module test_fiso_rx_channel;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [15:0] VEC_FLIT [NVEC] = '{
    16'h0000, 16'hFFFF, 16'h8001, 16'h1234,
    16'hA5A5, 16'h5A5A, 16'h0F0F, 16'hC3E1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lv = 1'b0;
  logic [19:0] lw = '0;
  logic [1:0]  credit;
  logic        fault;
  logic        restore = 1'b0;
  logic        dv;
  logic [15:0] df;
  logic        dr = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fiso_rx_channel i_fiso_rx_channel (
    .clk_i(clk), .rst_ni(rst_n), .link_valid_i(lv), .link_word_i(lw),
    .link_credit_o(credit), .link_fault_o(fault), .restore_i(restore),
    .dn_valid_o(dv), .dn_flit_o(df), .dn_ready_i(dr)
  );

  // Reference CRC by polynomial long division of d * x^4 by 10011
  function automatic logic [3:0] ref_crc(input logic [15:0] d);
    logic [19:0] r;
    r = {d, 4'b0000};
    for (int i = 19; i >= 4; i--)
      if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
    return r[3:0];
  endfunction

  function automatic logic [19:0] good_w(input logic [15:0] d);
    return {d, ref_crc(d)};
  endfunction

  function automatic logic [19:0] bad_w(input logic [15:0] d);
    return {d, ref_crc(d) ^ 4'b0001};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one word at a negedge; return at the following negedge with the link idle
  task automatic send(input logic [19:0] w);
    @(negedge clk);
    lv = 1'b1;
    lw = w;
    @(negedge clk);
    lv = 1'b0;
  endtask

  task automatic pulse_restore();
    @(negedge clk);
    restore = 1'b1;
    @(negedge clk);
    restore = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 fault", fault, 0);
    check("R9 dn_valid", dv, 0);
    check("R9 credit", credit, 0);

    // R3: corrupt the stored copy just before delivery
    dr = 1'b1;
    send(good_w(16'hBEEF));
    check("R1 head valid before upset", dv, 1);
    force i_fiso_rx_channel.u_buf.mem_q = {60'h0, bad_w(16'hBEEF)};
    #1;
    check("R3 bad head hidden", dv, 0);
    @(negedge clk);
    release i_fiso_rx_channel.u_buf.mem_q;
    check("R3 fault raised", fault, 1);
    check("R5 credit for scrapped head", credit, 1);
    check("R3 still hidden", dv, 0);
    pulse_restore();
    check("R8 restore clears fault", fault, 0);

    // R1/R5 table of good flits, downstream ready
    for (int i = 0; i < NVEC; i++) begin
      send(good_w(VEC_FLIT[i]));
      check("R1 valid", dv, 1);
      check("R1 flit", df, VEC_FLIT[i]);
      @(negedge clk);
      check("R5 credit after delivery", credit, 1);
      check("R1 drained", dv, 0);
      check("R1 no fault", fault, 0);
    end

    // R7: fill 4 with downstream stalled, then drain in order
    dr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lv = 1'b1;
      lw = good_w(16'h1000 + 16'(k));
    end
    @(negedge clk);
    lv = 1'b0;
    check("R7 head valid", dv, 1);
    check("R7 head order", df, 16'h1000);
    check("R7 no credit while held", credit, 0);
    dr = 1'b1;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check("R7 order", df, 16'h1000 + 16'(k));
      check("R7 credit per pop", credit, 1);
    end
    @(negedge clk);
    check("R7 empty after drain", dv, 0);
    check("R7 last credit", credit, 1);

    // R2/R6: fault mid-packet with two words buffered
    dr = 1'b0;
    @(negedge clk);
    lv = 1'b1; lw = good_w(16'h2001);
    @(negedge clk);
    lw = good_w(16'h2002);
    @(negedge clk);
    lw = bad_w(16'h2003);
    @(negedge clk);
    check("R2 fault after bad arrival", fault, 1);
    check("R5 credit for dropped bad word", credit, 1);
    check("R4 nothing offered", dv, 0);
    lw = good_w(16'h2004);
    @(negedge clk);
    lv = 1'b0;
    check("R6 double credit", credit, 2);
    check("R4 nothing offered while scrapping", dv, 0);
    @(negedge clk);
    check("R6 second scrap credit", credit, 1);
    @(negedge clk);
    check("R6 drained, no credit", credit, 0);

    // R4/R6: tail words while isolated, downstream ready
    dr = 1'b1;
    for (int k = 0; k < 2; k++) begin
      send(good_w(16'h3000 + 16'(k)));
      check("R4 tail blocked", dv, 0);
      check("R6 tail credit", credit, 1);
      check("R8 fault held", fault, 1);
    end

    // R8: restore then normal delivery
    pulse_restore();
    check("R8 fault cleared", fault, 0);
    send(good_w(16'h4444));
    check("R8 delivers after restore", df, 16'h4444);
    check("R8 valid after restore", dv, 1);
    @(negedge clk);

    // R8: restore flushes buffered words without credit
    dr = 1'b0;
    send(good_w(16'h5001));
    send(good_w(16'h5002));
    check("R8 held before flush", dv, 1);
    pulse_restore();
    check("R8 flushed", dv, 0);
    check("R8 no flush credit", credit, 0);
    dr = 1'b1;
    send(good_w(16'h5003));
    check("R8 fresh word after flush", df, 16'h5003);
    check("R8 fresh valid", dv, 1);
    @(negedge clk);
    check("R5 fresh credit", credit, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule